// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block turns the 16-bit requester ID of a PCIe transaction (bus, device, function) into a 6-bit stream identifier and a 3-bit access-controller ID. The IOMMU and the interrupt translation unit both consume these values. The table has 32 entries. Each entry holds a valid flag, a requester ID to compare against, a 16-bit compare mask, and the two result fields.

Software never writes an entry directly. It loads two staging registers and then writes an entry number into the control register. If the direction bit in that write is clear, the staged words are committed to the chosen entry. If the direction bit is set, the chosen entry is copied back into the staging registers, where software can read it.

On the lookup side, the match is evaluated combinationally against every entry. The lowest-numbered matching entry wins, and the result passes through one output register, so the answer appears one clock after the requester ID is presented.

Top module: `rid_stream_map`

## Requirements
- R1: After reset, no requester ID hits and all lookup outputs are zero. The control register reads 0, the first staging register reads 0 and the second staging register reads 0x0000FFFF (mask all ones).
- R2: A write to the control register (offset 0x08) with bit 16 clear commits both staging registers into the entry numbered by bits 4:0. The staging registers themselves are left unchanged.
- R3: An entry matches an incoming requester ID when the entry is valid and ((rid XOR entry_rid) AND entry_mask) is zero. Mask bits at 0 are don't-care, so a mask of 0xFFFF demands an exact match.
- R4: When several entries match, the outputs come from the lowest-numbered matching entry.
- R5: When no entry matches, the hit output is low and both the stream ID and the access-controller ID are zero.
- R6: A write to the control register with bit 16 set copies the numbered entry into the staging registers at that clock edge. The entry's contents are then readable there in the staging format.
- R7: The lookup outputs reflect the requester ID sampled at the previous rising clock edge. They do not change between edges.
- R8: The first staging register (offset 0x0C) keeps only bit 31 (valid), bits 10:8 (access-controller ID) and bits 5:0 (stream ID); every other bit reads as 0. The second staging register (offset 0x10) holds the requester ID in bits 31:16 and the mask in bits 15:0. Writes to any other offset change nothing.
- R9: An entry whose valid bit is clear never hits, even when its requester ID and mask would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the register at cfg_addr (combinational) |
| lk_rid | input | 16 | Requester ID to translate |
| lk_hit | output | 1 | Registered: some valid entry matched |
| lk_stream | output | 6 | Registered stream ID of the winning entry |
| lk_ctrl_id | output | 3 | Registered access-controller ID of the winning entry |

## Verification
The state that can go wrong sits mainly in the table entries: a wrong valid bit, a corrupted mask or a commit to the wrong entry number. Such a fault shows at the lookup outputs one clock after an affected requester ID is presented. It also shows in the staging registers one clock after a read-back command for that entry. For this reason every entry is both read back and swept over a dense range of requester IDs, with overlapping masked entries, so that priority faults and mask faults both reach a compared output.

// File: rtl/rid_map_pkg.sv
package rid_map_pkg;

    localparam int RID_W  = 16;
    localparam int SID_W  = 6;
    localparam int ACID_W = 3;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STA  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_STB  = 8'h10;
    localparam int DIR_BIT = 16;

    typedef struct packed {
        logic              valid;
        logic [ACID_W-1:0] acid;
        logic [SID_W-1:0]  sid;
        logic [RID_W-1:0]  rid;
        logic [RID_W-1:0]  mask;
    } entry_t;

    typedef struct packed {
        logic              hit;
        logic [ACID_W-1:0] acid;
        logic [SID_W-1:0]  sid;
    } result_t;

    function automatic logic [31:0] word_a(entry_t e);
        return {e.valid, 20'b0, e.acid, 2'b0, e.sid};
    endfunction

    function automatic logic [31:0] word_b(entry_t e);
        return {e.rid, e.mask};
    endfunction

    function automatic logic entry_match(entry_t e, logic [RID_W-1:0] rid);
        return e.valid && (((rid ^ e.rid) & e.mask) == '0);
    endfunction

endpackage

// File: rtl/rid_map_entry.sv
module rid_map_entry
    import rid_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  entry_t           wr_data,
    input  logic [RID_W-1:0] lk_rid,
    output entry_t           ent,
    output logic             hit
);
    always_ff @(posedge clk) begin
        if (rst)        ent <= '0;
        else if (wr_en) ent <= wr_data;
    end

    assign hit = entry_match(ent, lk_rid);
endmodule

// File: rtl/rid_map_pick.sv
module rid_map_pick
    import rid_map_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input  entry_t [N_ENT-1:0] ents,
    input  logic   [N_ENT-1:0] hits,
    output logic   [N_ENT-1:0] win,
    output result_t            res
);
    // isolate lowest set bit: lowest entry number has priority
    assign win = hits & (~hits + 1'b1);

    always_comb begin
        res = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (win[i]) begin
                res.hit  = 1'b1;
                res.acid = res.acid | ents[i].acid;
                res.sid  = res.sid  | ents[i].sid;
            end
        end
    end
endmodule

// File: rtl/rid_map_regs.sv
module rid_map_regs
    import rid_map_pkg::*;
#(
    parameter int N_ENT = 32,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  entry_t [N_ENT-1:0] ents,
    output logic               commit_en,
    output logic [IDX_W-1:0]   commit_idx,
    output entry_t             staged
);
    logic             ctrl_dir;
    logic [IDX_W-1:0] ctrl_idx;
    logic             ctrl_wr;

    assign ctrl_wr    = cfg_we && (cfg_addr == OFF_CTRL);
    assign commit_en  = ctrl_wr && !cfg_wdata[DIR_BIT];
    assign commit_idx = cfg_wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_dir    <= 1'b0;
            ctrl_idx    <= '0;
            staged      <= '0;
            staged.mask <= '1;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                OFF_CTRL: begin
                    ctrl_dir <= cfg_wdata[DIR_BIT];
                    ctrl_idx <= cfg_wdata[IDX_W-1:0];
                    if (cfg_wdata[DIR_BIT])
                        staged <= ents[cfg_wdata[IDX_W-1:0]];
                end
                OFF_STA: begin
                    staged.valid <= cfg_wdata[31];
                    staged.acid  <= cfg_wdata[8 +: ACID_W];
                    staged.sid   <= cfg_wdata[0 +: SID_W];
                end
                OFF_STB: begin
                    staged.rid  <= cfg_wdata[31:16];
                    staged.mask <= cfg_wdata[15:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (cfg_addr)
            OFF_CTRL: cfg_rdata = {15'b0, ctrl_dir, {(16-IDX_W){1'b0}}, ctrl_idx};
            OFF_STA:  cfg_rdata = word_a(staged);
            OFF_STB:  cfg_rdata = word_b(staged);
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rid_stream_map.sv
module rid_stream_map
    import rid_map_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [RID_W-1:0]   lk_rid,
    output logic               lk_hit,
    output logic [SID_W-1:0]   lk_stream,
    output logic [ACID_W-1:0]  lk_ctrl_id
);
    localparam int IDX_W = $clog2(N_ENT);

    entry_t [N_ENT-1:0] ents;
    logic   [N_ENT-1:0] hits;
    logic   [N_ENT-1:0] win_vec;
    logic               commit_en;
    logic [IDX_W-1:0]   commit_idx;
    entry_t             staged;
    result_t            res_d, res_q;

    rid_map_regs #(.N_ENT(N_ENT)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ents(ents),
        .commit_en(commit_en), .commit_idx(commit_idx), .staged(staged)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        rid_map_entry u_ent (
            .clk(clk), .rst(rst),
            .wr_en(commit_en && (commit_idx == IDX_W'(i))),
            .wr_data(staged), .lk_rid(lk_rid),
            .ent(ents[i]), .hit(hits[i])
        );
    end

    rid_map_pick #(.N_ENT(N_ENT)) u_pick (
        .ents(ents), .hits(hits), .win(win_vec), .res(res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign lk_hit     = res_q.hit;
    assign lk_stream  = res_q.sid;
    assign lk_ctrl_id = res_q.acid;
endmodule

// File: rtl/rid_map_chk.sv
module rid_map_chk
    import rid_map_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              lk_hit,
    input logic [SID_W-1:0]  lk_stream,
    input logic [ACID_W-1:0] lk_ctrl_id,
    input logic [N_ENT-1:0]  win_vec,
    input entry_t            staged
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!lk_hit && lk_stream == '0 && lk_ctrl_id == '0));

    a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_stream == '0 && lk_ctrl_id == '0));

    a_r4_single_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_vec));

    a_r2_commit_keeps_stage: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == OFF_CTRL && !cfg_wdata[DIR_BIT]) |=> $stable(staged));
endmodule

bind rid_stream_map rid_map_chk #(.N_ENT(N_ENT)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lk_hit(lk_hit), .lk_stream(lk_stream),
    .lk_ctrl_id(lk_ctrl_id), .win_vec(win_vec), .staged(staged)
);

// File: tb/rid_stream_map_test.sv
module rid_stream_map_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_we = 0;
    logic [7:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic [15:0] lk_rid = 0;
    logic        lk_hit;
    logic [5:0]  lk_stream;
    logic [2:0]  lk_ctrl_id;

    int n_chk = 0;
    int n_fail = 0;

    logic        m_v   [N];
    logic [2:0]  m_ac  [N];
    logic [5:0]  m_sid [N];
    logic [15:0] m_rid [N];
    logic [15:0] m_msk [N];

    rid_stream_map uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [9:0] model(logic [15:0] r);
        for (int i = 0; i < N; i++)
            if (m_v[i] && (((r ^ m_rid[i]) & m_msk[i]) == 16'h0))
                return {1'b1, m_ac[i], m_sid[i]};
        return 10'h0;
    endfunction

    task automatic prog(int idx, logic v, logic [2:0] ac, logic [5:0] sid,
                        logic [15:0] r, logic [15:0] msk);
        wr(8'h0C, {v, 20'b0, ac, 2'b0, sid});
        wr(8'h10, {r, msk});
        wr(8'h08, 32'(idx));
        m_v[idx] = v; m_ac[idx] = ac; m_sid[idx] = sid;
        m_rid[idx] = r; m_msk[idx] = msk;
    endtask

    task automatic look(string tag, logic [15:0] r);
        @(negedge clk);
        lk_rid = r;
        @(negedge clk);
        check(tag, {22'b0, lk_hit, lk_ctrl_id, lk_stream}, {22'b0, model(r)});
    endtask

    initial begin
        logic [31:0] d;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_ac[i] = 0; m_sid[i] = 0; m_rid[i] = 0; m_msk[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        @(negedge clk);
        check("R1 outputs", {22'b0, lk_hit, lk_ctrl_id, lk_stream}, 32'h0);
        rd(8'h08, d); check("R1 ctrl", d, 32'h0);
        rd(8'h0C, d); check("R1 stage A", d, 32'h0);
        rd(8'h10, d); check("R1 stage B", d, 32'h0000FFFF);
        look("R1 R9 no hit after reset", 16'h0000);
        look("R1 R9 no hit after reset", 16'h1234);

        // R8: field layout and ignored writes
        wr(8'h0C, 32'hFFFFFFFF);
        rd(8'h0C, d); check("R8 stage A bits", d, 32'h8000073F);
        wr(8'h14, 32'hDEADBEEF);
        wr(8'h00, 32'h12345678);
        rd(8'h0C, d); check("R8 stray write A", d, 32'h8000073F);
        rd(8'h10, d); check("R8 stray write B", d, 32'h0000FFFF);
        rd(8'h14, d); check("R8 unmapped read", d, 32'h0);

        // R2 R3 R9: consecutive rids, consecutive stream ids, entry 5 invalid
        for (int i = 0; i < N; i++)
            prog(i, (i != 5), 3'(i % 8), 6'(32 + i), 16'h0100 + 16'(i), 16'hFFFF);
        rd(8'h08, d); check("R2 ctrl holds index", d, 32'h0000001F);
        for (int r = 16'h00F8; r < 16'h0128; r++)
            look("R2 R3 R5 R9 exact sweep", 16'(r));

        // R7: one-cycle latency
        @(negedge clk); lk_rid = 16'h0FFF;
        @(negedge clk);
        check("R7 miss settled", {22'b0, lk_hit, lk_ctrl_id, lk_stream}, 32'h0);
        lk_rid = 16'h0100;
        #1 check("R7 unchanged before edge", {22'b0, lk_hit, lk_ctrl_id, lk_stream}, 32'h0);
        @(negedge clk);
        check("R7 result after edge", {22'b0, lk_hit, lk_ctrl_id, lk_stream},
              {22'b0, 1'b1, 3'd0, 6'd32});

        // R3 R4: masked overlapping entries
        prog(2, 1, 3'd1, 6'd7, 16'h0200, 16'hFF00);
        prog(1, 1, 3'd2, 6'd9, 16'h0234, 16'hFFFF);
        prog(3, 1, 3'd4, 6'd11, 16'h0201, 16'hFF0F);
        prog(0, 1, 3'd6, 6'd0, 16'h0000, 16'h0000);
        for (int r = 16'h0200; r < 16'h0300; r++)
            look("R3 R4 masked sweep", 16'(r));
        prog(0, 0, 3'd0, 6'd0, 16'h0100, 16'hFFFF);
        for (int r = 16'h01F0; r < 16'h0310; r += 3)
            look("R3 R4 masked sweep 2", 16'(r));

        // R6: read back every entry
        for (int i = 0; i < N; i++) begin
            wr(8'h08, 32'h00010000 | 32'(i));
            rd(8'h0C, d);
            check("R6 readback A", d, {m_v[i], 20'b0, m_ac[i], 2'b0, m_sid[i]});
            rd(8'h10, d);
            check("R6 readback B", d, {m_rid[i], m_msk[i]});
        end
        rd(8'h08, d); check("R6 ctrl dir bit", d, 32'h0001001F);
        look("R6 table intact", 16'h0234);
        look("R6 table intact", 16'h0110);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule